// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the memory side of an asynchronous DRAM interface. It watches the four active-low control strobes (row strobe, column strobe, write enable, output enable) together with the multiplexed address bus. It samples them with a fast local clock and works out which kind of memory cycle the controller has just run. The kind is found from the order in which the strobes move, not from their levels at one instant. A column strobe that is already low when the row strobe falls marks a counter-driven refresh. A write enable that is low before the column strobe falls marks an early write. A write enable that falls after the column strobe marks a read-write.

The block latches the row and column addresses and drives an output-enable for the data bus. That enable follows extended-data-out rules: data stays driven past the rising column strobe until the next column access, or until output enable or write enable takes it away. When both strobes return high, the block emits a single pulse carrying the cycle kind and the row that the cycle refreshed. For counter-driven refreshes, that row comes from an internal refresh counter, and the counter then advances. The storage array is not part of the block.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, and in any cycle that follows a sampled state with both row and column strobes high, `dq_oe` is low. After reset, `cyc_valid` is low.
- R2: Each memory cycle ends when both strobes are sampled high. At that point `cyc_valid` pulses high for exactly one clock, with `cyc_kind` coded as: 0 standby, 1 read, 2 early write, 3 read-write, 4 hidden refresh, 5 row-only refresh, 6 column-before-row refresh. No cycle produces more than one pulse.
- R3: A column strobe fall while the row strobe is low and write enable is high starts a read (kind 1). `dq_oe` then rises while output enable is low and write enable is high.
- R4: Write enable low at the column strobe fall makes an early write (kind 2). `dq_oe` stays low for the whole cycle, even if output enable is low or write enable later rises.
- R5: Write enable falling after the column strobe fall of a read turns the cycle into a read-write (kind 3), and `dq_oe` drops.
- R6: A row strobe fall with the column strobe high, with no column strobe fall before the row strobe rises, is a row-only refresh (kind 5). `ref_row` equals the row address latched at the row strobe fall.
- R7: The column strobe low at the row strobe fall makes a counter refresh (kind 6). The address bus is ignored (`row_q` keeps its value) and `dq_oe` stays low. `ref_row` carries the refresh counter, which starts at 0 after reset, advances by one after each counter or hidden refresh, and wraps to 0 after its all-ones value.
- R8: With the column strobe held low after a read, a row strobe rise and then fall makes a hidden refresh (kind 4). `dq_oe` stays high throughout, `row_q` is unchanged, and `ref_row` carries the refresh counter.
- R9: During a page, `dq_oe` stays high after the column strobe rises. It clears at the next column strobe fall, when output enable goes high, or when write enable goes low.
- R10: `row_q` takes the address at the row strobe fall of a non-refresh cycle. `col_q` takes the low `COL_W` address bits at each column strobe fall of an access. For read, write and row-only cycles, `ref_row` equals `row_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_strobe_n | input | 1 | Active-low row address strobe |
| col_strobe_n | input | 1 | Active-low column address strobe |
| wr_en_n | input | 1 | Active-low write enable |
| out_en_n | input | 1 | Active-low output enable |
| addr | input | ROW_W | Multiplexed row/column address |
| cyc_valid | output | 1 | One-clock pulse at the end of each cycle |
| cyc_kind | output | 3 | Cycle kind code, valid with `cyc_valid` |
| row_q | output | ROW_W | Latched row address |
| col_q | output | COL_W | Latched column address |
| ref_row | output | ROW_W | Row refreshed by the finished cycle, valid with `cyc_valid` |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the decoder with `ROW_W` = 8 and `COL_W` = 7, leaving the synchronizer depth at two. A full lap of the refresh counter is then 256 counter refreshes, so the bench can run the counter through its all-ones value and see it wrap to 0. It also checks that hidden refreshes share the same counter sequence. The narrower column field still leaves the row field wider than the column field, so the column is taken from the low address bits as it is at the default sizes.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

   typedef enum logic [2:0] {
      CK_STANDBY = 3'd0,
      CK_READ    = 3'd1,
      CK_EWRITE  = 3'd2,
      CK_RDWR    = 3'd3,
      CK_HIDDEN  = 3'd4,
      CK_RASONLY = 3'd5,
      CK_CBR     = 3'd6
   } cyc_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ROW,
      S_COL,
      S_CBR,
      S_TAIL,
      S_HID
   } dec_state_e;

endpackage

// File: rtl/dram_strobe_sync.sv
module dram_strobe_sync #(
   parameter int WIDTH    = 4,
   parameter int STAGES   = 2,
   parameter bit RST_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);
   localparam logic [WIDTH-1:0] RST_V = RST_HIGH ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dram_strobe_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("dram_strobe_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe   <= {STAGES{RST_V}};
         q_prev <= RST_V;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         q_prev <= pipe[STAGES-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   generate
      if (W < 2) begin : g_bad_w
         $error("dram_refresh_ctr: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   // R7: the counter moves only when a refresh finishes
   assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt));

endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
   import dram_dec_pkg::*;
#(
   parameter int ROW_W = 10,
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_ras,
   input  logic             s_cas,
   input  logic             s_we,
   input  logic             s_oe,
   input  logic             ras_fall,
   input  logic             cas_fall,
   input  logic [ROW_W-1:0] addr,
   input  logic [ROW_W-1:0] ref_cnt,
   output logic             refresh_inc,
   output logic             cyc_valid,
   output cyc_kind_e        cyc_kind,
   output logic [ROW_W-1:0] row_q,
   output logic [COL_W-1:0] col_q,
   output logic [ROW_W-1:0] ref_row,
   output logic             dq_oe
);
   dec_state_e st;
   cyc_kind_e  kind;
   logic       both_high;
   logic       finishing;
   logic       is_refresh;

   assign both_high   = s_ras & s_cas;
   assign finishing   = (st != S_IDLE) && both_high;
   assign is_refresh  = (kind == CK_CBR) || (kind == CK_HIDDEN);
   assign refresh_inc = finishing && is_refresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         kind      <= CK_STANDBY;
         row_q     <= '0;
         col_q     <= '0;
         ref_row   <= '0;
         cyc_valid <= 1'b0;
         cyc_kind  <= CK_STANDBY;
      end else begin
         cyc_valid <= 1'b0;
         if (finishing) begin
            cyc_valid <= 1'b1;
            cyc_kind  <= kind;
            ref_row   <= is_refresh ? ref_cnt : row_q;
            st        <= S_IDLE;
         end else begin
            unique case (st)
               S_IDLE: if (ras_fall) begin
                  if (!s_cas) begin
                     st   <= S_CBR;
                     kind <= CK_CBR;
                  end else begin
                     st    <= S_ROW;
                     kind  <= CK_RASONLY;
                     row_q <= addr;
                  end
               end
               S_ROW: if (cas_fall) begin
                  st    <= S_COL;
                  col_q <= addr[COL_W-1:0];
                  kind  <= s_we ? CK_READ : CK_EWRITE;
               end
               S_COL: begin
                  if (s_ras)                          st   <= S_TAIL;
                  else if (s_cas)                     st   <= S_ROW;
                  else if (!s_we && kind == CK_READ)  kind <= CK_RDWR;
               end
               S_TAIL: if (ras_fall) begin
                  st   <= S_HID;
                  kind <= CK_HIDDEN;
               end
               S_CBR, S_HID: ;
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // data bus drive, extended-data-out hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dq_oe <= 1'b0;
      else if (both_high || s_oe || !s_we || cas_fall || st == S_CBR)
         dq_oe <= 1'b0;
      else if (st == S_COL && kind == CK_READ)
         dq_oe <= 1'b1;
   end

   // R2: one pulse per cycle
   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |=> !cyc_valid);

   // R1: bus released once both strobes were high
   assert_hiz_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s_ras && s_cas) |-> !dq_oe);

   // R4: an early write never drives the bus
   assert_no_drive_ewrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_COL && kind == CK_EWRITE) |-> !dq_oe);

   // R7: idle and counter refresh never drive the bus
   assert_no_drive_cbr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE || st == S_CBR) |-> !dq_oe);

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
   import dram_dec_pkg::*;
#(
   parameter int ROW_W       = 10,
   parameter int COL_W       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_strobe_n,
   input  logic             col_strobe_n,
   input  logic             wr_en_n,
   input  logic             out_en_n,
   input  logic [ROW_W-1:0] addr,
   output logic             cyc_valid,
   output logic [2:0]       cyc_kind,
   output logic [ROW_W-1:0] row_q,
   output logic [COL_W-1:0] col_q,
   output logic [ROW_W-1:0] ref_row,
   output logic             dq_oe
);
   localparam int NSTRB = 4;

   generate
      if (COL_W > ROW_W) begin : g_bad_col
         $error("dram_cycle_decoder: COL_W must not exceed ROW_W");
      end
   endgenerate

   logic [NSTRB-1:0] strb_s, strb_p;
   logic [ROW_W-1:0] addr_s, addr_p;
   logic [ROW_W-1:0] ref_cnt;
   logic             refresh_inc;
   cyc_kind_e        kind_w;

   dram_strobe_sync #(.WIDTH(NSTRB), .STAGES(SYNC_STAGES), .RST_HIGH(1'b1)) u_strb_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      ({out_en_n, wr_en_n, col_strobe_n, row_strobe_n}),
      .q      (strb_s),
      .q_prev (strb_p)
   );

   dram_strobe_sync #(.WIDTH(ROW_W), .STAGES(SYNC_STAGES), .RST_HIGH(1'b0)) u_addr_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (addr),
      .q      (addr_s),
      .q_prev (addr_p)
   );

   dram_refresh_ctr #(.W(ROW_W)) u_ref_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (refresh_inc),
      .cnt   (ref_cnt)
   );

   dram_cycle_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .s_ras       (strb_s[0]),
      .s_cas       (strb_s[1]),
      .s_we        (strb_s[2]),
      .s_oe        (strb_s[3]),
      .ras_fall    (strb_p[0] & ~strb_s[0]),
      .cas_fall    (strb_p[1] & ~strb_s[1]),
      .addr        (addr_s),
      .ref_cnt     (ref_cnt),
      .refresh_inc (refresh_inc),
      .cyc_valid   (cyc_valid),
      .cyc_kind    (kind_w),
      .row_q       (row_q),
      .col_q       (col_q),
      .ref_row     (ref_row),
      .dq_oe       (dq_oe)
   );

   assign cyc_kind = kind_w;

   // R7: a refresh reports the counter value it used, and the counter then advances
   assert_ref_from_counter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && (cyc_kind == CK_CBR || cyc_kind == CK_HIDDEN))
         |-> ref_row == ROW_W'(ref_cnt - 1'b1));

   // R2: no cycle kind code beyond the defined set
   assert_kind_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> cyc_kind <= 3'd6);

endmodule

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
   localparam int ROW_W = 8;
   localparam int COL_W = 7;
   localparam int HOLD  = 6;

   localparam logic [2:0] K_READ = 3'd1, K_EWR = 3'd2, K_RDWR = 3'd3,
                          K_HID = 3'd4, K_RAS = 3'd5, K_CBR = 3'd6;

   typedef struct packed {
      logic [2:0]       kind;
      logic [ROW_W-1:0] row;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [ROW_W-1:0] addr = '0;
   logic             cyc_valid;
   logic [2:0]       cyc_kind;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] ref_row;
   logic             dq_oe;

   int n_cmp = 0;
   int n_bad = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   dram_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n),
      .row_strobe_n(ras_n), .col_strobe_n(cas_n), .wr_en_n(we_n), .out_en_n(oe_n),
      .addr(addr),
      .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .row_q(row_q), .col_q(col_q),
      .ref_row(ref_row), .dq_oe(dq_oe)
   );

   function automatic string tag_of(input logic [2:0] k);
      case (k)
         K_READ:  return "R3";
         K_EWR:   return "R4";
         K_RDWR:  return "R5";
         K_HID:   return "R8";
         K_RAS:   return "R6";
         K_CBR:   return "R7";
         default: return "R2";
      endcase
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic drive(input logic r, input logic c, input logic w, input logic o,
                        input logic [ROW_W-1:0] a);
      @(negedge clk);
      ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic expect_cycle(input logic [2:0] k, input logic [ROW_W-1:0] r);
      sb.push_back('{kind: k, row: r});
   endtask

   // monitor: compare every end-of-cycle pulse against the scoreboard
   always @(negedge clk) begin
      if (rst_n && cyc_valid) begin
         if (sb.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: unexpected pulse kind %0d, expected none", cyc_kind);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({tag_of(e.kind), " kind"}, cyc_kind, e.kind);
            check({tag_of(e.kind), "/R10 ref_row"}, ref_row, e.row);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 dq_oe after reset", dq_oe, 0);
      check("R1 cyc_valid after reset", cyc_valid, 0);

      // read with extended data-out
      drive(0, 1, 1, 1, 8'h5A);
      check("R10 row_q", row_q, 8'h5A);
      drive(0, 0, 1, 0, 8'h2B);
      check("R3 dq_oe on read", dq_oe, 1);
      check("R10 col_q", col_q, 7'h2B);
      drive(0, 1, 1, 0, 8'h2B);
      check("R9 hold after column strobe rise", dq_oe, 1);
      expect_cycle(K_READ, 8'h5A);
      drive(1, 1, 1, 0, 8'h00);
      check("R1 release at standby", dq_oe, 0);

      // page read: output enable and write enable release the bus
      drive(0, 1, 1, 1, 8'h11);
      drive(0, 0, 1, 0, 8'h03);
      check("R3 page first access", dq_oe, 1);
      drive(0, 1, 1, 0, 8'h04);
      check("R9 page hold", dq_oe, 1);
      drive(0, 1, 1, 1, 8'h04);
      check("R9 release by output enable", dq_oe, 0);
      drive(0, 0, 1, 0, 8'h05);
      check("R9 second access drives", dq_oe, 1);
      check("R10 col_q second access", col_q, 7'h05);
      drive(0, 1, 1, 0, 8'h05);
      drive(0, 1, 0, 0, 8'h05);
      check("R9 release by write enable", dq_oe, 0);
      expect_cycle(K_READ, 8'h11);
      drive(1, 1, 1, 1, 8'h00);

      // early write
      drive(0, 1, 1, 1, 8'h7E);
      drive(0, 1, 0, 0, 8'h7E);
      drive(0, 0, 0, 0, 8'h12);
      check("R4 no drive on early write", dq_oe, 0);
      drive(0, 0, 1, 0, 8'h12);
      check("R4 no drive after write enable rises", dq_oe, 0);
      expect_cycle(K_EWR, 8'h7E);
      drive(1, 1, 1, 1, 8'h00);

      // read-write
      drive(0, 1, 1, 1, 8'h33);
      drive(0, 0, 1, 0, 8'h21);
      check("R3 read part drives", dq_oe, 1);
      drive(0, 0, 0, 0, 8'h21);
      check("R5 late write releases", dq_oe, 0);
      expect_cycle(K_RDWR, 8'h33);
      drive(1, 1, 1, 1, 8'h00);

      // row-only refresh
      drive(0, 1, 1, 0, 8'hC4);
      check("R6 no drive on row-only", dq_oe, 0);
      expect_cycle(K_RAS, 8'hC4);
      drive(1, 1, 1, 1, 8'h00);

      // counter refresh, address ignored
      drive(1, 0, 1, 1, 8'h99);
      drive(0, 0, 1, 0, 8'h99);
      check("R7 address ignored", row_q, 8'hC4);
      check("R7 no drive on counter refresh", dq_oe, 0);
      drive(1, 0, 1, 1, 8'h99);
      expect_cycle(K_CBR, 8'h00);
      drive(1, 1, 1, 1, 8'h00);

      // hidden refresh after a read
      drive(0, 1, 1, 1, 8'h40);
      drive(0, 0, 1, 0, 8'h06);
      check("R3 read before hidden", dq_oe, 1);
      drive(1, 0, 1, 0, 8'hEE);
      check("R8 data held, row strobe high", dq_oe, 1);
      drive(0, 0, 1, 0, 8'hEE);
      check("R8 data held during refresh", dq_oe, 1);
      check("R8 row_q unchanged", row_q, 8'h40);
      expect_cycle(K_HID, 8'h01);
      drive(1, 1, 1, 0, 8'h00);

      // run the counter through its wrap
      for (int i = 2; i <= (1 << ROW_W); i++) begin
         drive(1, 0, 1, 1, 8'h00);
         drive(0, 0, 1, 1, ROW_W'(i * 7));
         expect_cycle(K_CBR, ROW_W'(i));
         drive(1, 1, 1, 1, 8'h00);
      end

      repeat (10) @(negedge clk);
      check("R2 every expected pulse seen", sb.size(), 0);
      check("R1 final standby", dq_oe, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule